// File: doc/BRIEF.md
# Three-Step Hybrid Vector Rotator

This block rotates a complex sample `(x, y)` counter-clockwise by an angle between 0 and π/4. The angle arrives as a 13-bit unsigned code, and one code step is (π/4)·2^-13 rad. Both components of the input are 12-bit two's complement. Both components of the output are 13-bit two's complement. A phase rotator or frequency-offset corrector uses it after octant folding, which is done elsewhere, has reduced the angle to the first half-quadrant.

The rotation is split into three steps.

1. Shift-add micro-rotations with an angle recursion bring the coarse part of the angle to within about 2^-5 rad. The leftover angle and the six low code bits then form a small residual angle.
2. A second set of shift-add micro-rotations takes its six directions straight from bits of that residual after a constant offset is added. No recursion is needed, so all six directions are known at once.
3. The sub-2^-9 rad remainder is applied with two multiplications, using sin ≈ angle and cos ≈ 1. The two correction terms stay beside the base terms until a pair of merging adders combines them.

The merging adders also remove the fixed micro-rotation gain with one constant multiply, then round. A valid bit travels with the data, and a stage register holds its contents while no valid sample passes.

Top module: `hybrid_rotator`

## Requirements
- R1: `out_valid` equals the `in_valid` value that was captured four rising edges earlier. Exactly one register stage is used per step, plus the output stage.
- R2: A phase code of 0 returns the input vector unchanged, within ±2 LSB on each component.
- R3: For any input vector and any phase code from 0 to 8191, each output component is within ±2 LSB of `round(x·cosθ − y·sinθ)` and `round(x·sinθ + y·cosθ)`, where θ = code·(π/4)/8192. The output is in the input's scale, so no gain factor is left in the result.
- R4: The second step's direction word is the residual angle plus a fixed offset. It stays within [0, 2^15) in units of 2^-18 rad, and its bits 14 down to 9 select the directions of micro-rotations 2^-5 down to 2^-10. This holds for every code, including codes whose six low bits are all ones.
- R5: The third step's correction terms never exceed the opposite component shifted right by nine, plus one. This means the remainder angle is below 2^-9 rad for every value of the six low code bits.
- R6: While `rst` is high, `out_valid`, `out_x` and `out_y` are 0.
- R7: A cycle with `in_valid` low does not change `out_x` or `out_y` four edges later, whatever values the data inputs carry.
- R8: Full-scale inputs such as (−2048, −2048) and (2047, −2048) at the largest code produce in-range results within ±2 LSB. No intermediate value wraps.
- R9: Samples presented on consecutive cycles are all accepted, and each result appears on its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_x | input | 12 | Real part, two's complement |
| in_y | input | 12 | Imaginary part, two's complement |
| in_phase | input | 13 | Angle code, LSB weight (π/4)·2^-13 rad |
| out_valid | output | 1 | Result present |
| out_x | output | 13 | Rotated real part, two's complement |
| out_y | output | 13 | Rotated imaginary part, two's complement |

## Verification
Every result, including the valid flag, is due on the fourth rising edge after the edge that captured its sample. No other output timing exists, because each step owns one register and the merge owns the last one. The bench drives inputs on falling edges and records each driven sample, with its expected vector and requirement tag, in a slot indexed by drive count. Before each new drive it samples the outputs on the falling edge and compares them against the slot written four drives earlier. Cycles whose recorded sample was not valid are instead checked for a low flag and unchanged data.

// File: rtl/hr_pkg.sv
package hr_pkg;

  // Angle fraction bits inside the pipeline: one unit is 2^-18 rad.
  localparam int ANG_FB = 18;

  // Radians per phase code, scaled by 2^(ANG_FB-13+RAD_SH), i.e. round(pi/4 * 2^15).
  localparam int RAD_SH  = 10;
  localparam int RAD_Q10 = 25736;

  // Inverse of the total micro-rotation gain (about 1.647564), scaled by 2^14.
  localparam int GINV_FB = 14;
  localparam int GINV_Q  = 9944;

  // arctan(2^-i) in units of 2^-18 rad.
  function automatic int atan_q(input int i);
    case (i)
      0: return 205887;
      1: return 121542;
      2: return 64220;
      3: return 32599;
      4: return 16363;
      5: return 8189;
      6: return 4096;
      7: return 2048;
      default: return 0;
    endcase
  endfunction

  // Sum of 2^-k for k = first .. first+n-1, in units of 2^-18 rad.
  function automatic int bd_offset(input int first, input int n);
    int s;
    s = 0;
    for (int k = 0; k < n; k++) s += 1 << (ANG_FB - first - k);
    return s;
  endfunction

  function automatic logic [31:0] mag32(input logic signed [31:0] a);
    return (a < 0) ? 32'(-a) : 32'(a);
  endfunction

endpackage

// File: rtl/hr_coarse.sv
module hr_coarse #(
  parameter int IN_W  = 12,
  parameter int W     = 20,
  parameter int PH_W  = 13,
  parameter int LO_W  = 6,
  parameter int GUARD = 6,
  parameter int N_IT  = 6,
  parameter int N_BD  = 6,
  parameter int ANG_W = 21,
  parameter int V_W   = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_in,
  input  logic signed [IN_W-1:0]  x_in,
  input  logic signed [IN_W-1:0]  y_in,
  input  logic [PH_W-1:0]         ph_in,
  output logic                    v_q,
  output logic signed [W-1:0]     x_q,
  output logic signed [W-1:0]     y_q,
  output logic [V_W-1:0]          off_q
);
  localparam int FIRST_BD = N_IT - 1;
  localparam int OFFS     = hr_pkg::bd_offset(FIRST_BD, N_BD);
  localparam int PW       = PH_W + 16;

  logic [PW-1:0]            hi_prod, lo_prod;
  logic signed [ANG_W-1:0]  th_hi, beta, cz, nxt_off;
  logic signed [W-1:0]      cx, cy, tx;

  // Phase split: coarse part goes through the angle recursion, low subword waits.
  always_comb begin
    hi_prod = PW'({ph_in[PH_W-1:LO_W], {LO_W{1'b0}}}) * PW'(hr_pkg::RAD_Q10);
    lo_prod = PW'(ph_in[LO_W-1:0]) * PW'(hr_pkg::RAD_Q10);
    th_hi   = ANG_W'((hi_prod + PW'(1 << (hr_pkg::RAD_SH - 1))) >> hr_pkg::RAD_SH);
    beta    = ANG_W'((lo_prod + PW'(1 << (hr_pkg::RAD_SH - 1))) >> hr_pkg::RAD_SH);
  end

  // Step one: shift-add micro-rotations steered by the sign of the residual.
  always_comb begin
    cx = W'(x_in) <<< GUARD;
    cy = W'(y_in) <<< GUARD;
    cz = th_hi;
    for (int i = 0; i < N_IT; i++) begin
      tx = cx;
      if (cz[ANG_W-1]) begin
        cx = cx + (cy >>> i);
        cy = cy - (tx >>> i);
        cz = cz + ANG_W'(hr_pkg::atan_q(i));
      end else begin
        cx = cx - (cy >>> i);
        cy = cy + (tx >>> i);
        cz = cz - ANG_W'(hr_pkg::atan_q(i));
      end
    end
    nxt_off = cz + beta + ANG_W'(OFFS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      off_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        x_q   <= cx;
        y_q   <= cy;
        off_q <= nxt_off[V_W-1:0];
      end
    end
  end

  // R4: the offset residual always fits the direction-bit window.
  assert_dir_range_R4: assert property (@(posedge clk) disable iff (rst)
    v_in |-> (nxt_off >= 0 && nxt_off < (ANG_W'(1) <<< V_W)));

  assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));

endmodule

// File: rtl/hr_bitdir.sv
module hr_bitdir #(
  parameter int W     = 20,
  parameter int V_W   = 15,
  parameter int FIRST = 5,
  parameter int N_BD  = 6,
  parameter int G2_W  = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  y_in,
  input  logic [V_W-1:0]       off_in,
  output logic                 v_q,
  output logic signed [W-1:0]  x_q,
  output logic signed [W-1:0]  y_q,
  output logic [G2_W-1:0]      g2_q
);
  logic signed [W-1:0] cx, cy, tx;

  // Step two: every direction is one bit of the offset word, known in parallel.
  always_comb begin
    cx = x_in;
    cy = y_in;
    for (int k = 0; k < N_BD; k++) begin
      tx = cx;
      if (off_in[V_W-1-k]) begin
        cx = cx - (cy >>> (FIRST + k));
        cy = cy + (tx >>> (FIRST + k));
      end else begin
        cx = cx + (cy >>> (FIRST + k));
        cy = cy - (tx >>> (FIRST + k));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
      g2_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        x_q  <= cx;
        y_q  <= cy;
        g2_q <= off_in[G2_W-1:0];
      end
    end
  end

  assert_stage2_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));

endmodule

// File: rtl/hr_small_angle.sv
module hr_small_angle #(
  parameter int W    = 20,
  parameter int G2_W = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  y_in,
  input  logic [G2_W-1:0]      g2_in,
  output logic                 v_q,
  output logic signed [W-1:0]  xb_q,
  output logic signed [W-1:0]  xc_q,
  output logic signed [W-1:0]  yb_q,
  output logic signed [W-1:0]  yc_q
);
  localparam int PW = W + G2_W + 1;

  logic signed [G2_W:0] g2s;
  logic signed [W-1:0]  xc_n, yc_n;

  // Step three: sin(g) ~ g, cos(g) ~ 1; corrections kept apart from the base.
  always_comb begin
    g2s  = $signed({1'b0, g2_in});
    xc_n = -W'((PW'(y_in) * PW'(g2s)) >>> hr_pkg::ANG_FB);
    yc_n =  W'((PW'(x_in) * PW'(g2s)) >>> hr_pkg::ANG_FB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      xb_q <= '0;
      xc_q <= '0;
      yb_q <= '0;
      yc_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        xb_q <= x_in;
        xc_q <= xc_n;
        yb_q <= y_in;
        yc_q <= yc_n;
      end
    end
  end

  // R5: corrections bounded by the opposite base over 2^(ANG_FB-G2_W).
  assert_small_corr_R5: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (hr_pkg::mag32(32'(xc_q)) <= (hr_pkg::mag32(32'(yb_q)) >> (hr_pkg::ANG_FB - G2_W)) + 1 &&
             hr_pkg::mag32(32'(yc_q)) <= (hr_pkg::mag32(32'(xb_q)) >> (hr_pkg::ANG_FB - G2_W)) + 1));

  assert_stage3_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));

endmodule

// File: rtl/hr_merge.sv
module hr_merge #(
  parameter int W     = 20,
  parameter int OUT_W = 13,
  parameter int GUARD = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v_in,
  input  logic signed [W-1:0]      xb_in,
  input  logic signed [W-1:0]      xc_in,
  input  logic signed [W-1:0]      yb_in,
  input  logic signed [W-1:0]      yc_in,
  output logic                     v_q,
  output logic signed [OUT_W-1:0]  x_q,
  output logic signed [OUT_W-1:0]  y_q
);
  localparam int PW = W + 17;
  localparam int SH = hr_pkg::GINV_FB + GUARD;
  localparam logic signed [PW-1:0] GK   = PW'(hr_pkg::GINV_Q);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] OMAX = (PW'(1) <<< (OUT_W - 1)) - 1;
  localparam logic signed [PW-1:0] OMIN = -OMAX - 1;

  logic signed [W:0]    sx, sy;
  logic signed [PW-1:0] rx, ry;
  logic signed [OUT_W-1:0] ox, oy;

  // Vector-merging adders, then one constant multiply removes the gain.
  always_comb begin
    sx = (W+1)'(xb_in) + (W+1)'(xc_in);
    sy = (W+1)'(yb_in) + (W+1)'(yc_in);
    rx = ((PW'(sx) * GK) + HALF) >>> SH;
    ry = ((PW'(sy) * GK) + HALF) >>> SH;
    if (rx > OMAX)      ox = OUT_W'(OMAX);
    else if (rx < OMIN) ox = OUT_W'(OMIN);
    else                ox = OUT_W'(rx);
    if (ry > OMAX)      oy = OUT_W'(OMAX);
    else if (ry < OMIN) oy = OUT_W'(OMIN);
    else                oy = OUT_W'(ry);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      x_q <= '0;
      y_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        x_q <= ox;
        y_q <= oy;
      end
    end
  end

  assert_out_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(v_in)) |-> ($stable(x_q) && $stable(y_q)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    v_in |-> (rx <= OMAX && rx >= OMIN && ry <= OMAX && ry >= OMIN));

endmodule

// File: rtl/hybrid_rotator.sv
module hybrid_rotator #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 13,
  parameter int PH_W   = 13,
  parameter int LO_W   = 6,
  parameter int GUARD  = 6,
  parameter int N_IT   = 6,
  parameter int N_BD   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_x,
  input  logic signed [IN_W-1:0]   in_y,
  input  logic [PH_W-1:0]          in_phase,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_x,
  output logic signed [OUT_W-1:0]  out_y
);
  localparam int W     = IN_W + 2 + GUARD;
  localparam int ANG_W = hr_pkg::ANG_FB + 3;
  localparam int FIRST = N_IT - 1;
  localparam int V_W   = hr_pkg::ANG_FB + 2 - FIRST;
  localparam int G2_W  = V_W - N_BD;

  logic                v1, v2, v3;
  logic signed [W-1:0] x1, y1, x2, y2, xb, xc, yb, yc;
  logic [V_W-1:0]      off1;
  logic [G2_W-1:0]     g2;

  hr_coarse #(.IN_W(IN_W), .W(W), .PH_W(PH_W), .LO_W(LO_W), .GUARD(GUARD),
              .N_IT(N_IT), .N_BD(N_BD), .ANG_W(ANG_W), .V_W(V_W)) u_coarse (
    .clk(clk), .rst(rst), .v_in(in_valid), .x_in(in_x), .y_in(in_y),
    .ph_in(in_phase), .v_q(v1), .x_q(x1), .y_q(y1), .off_q(off1));

  hr_bitdir #(.W(W), .V_W(V_W), .FIRST(FIRST), .N_BD(N_BD), .G2_W(G2_W)) u_bitdir (
    .clk(clk), .rst(rst), .v_in(v1), .x_in(x1), .y_in(y1), .off_in(off1),
    .v_q(v2), .x_q(x2), .y_q(y2), .g2_q(g2));

  hr_small_angle #(.W(W), .G2_W(G2_W)) u_small (
    .clk(clk), .rst(rst), .v_in(v2), .x_in(x2), .y_in(y2), .g2_in(g2),
    .v_q(v3), .xb_q(xb), .xc_q(xc), .yb_q(yb), .yc_q(yc));

  hr_merge #(.W(W), .OUT_W(OUT_W), .GUARD(GUARD)) u_merge (
    .clk(clk), .rst(rst), .v_in(v3), .xb_in(xb), .xc_in(xc), .yb_in(yb),
    .yc_in(yc), .v_q(out_valid), .x_q(out_x), .y_q(out_y));

endmodule

// File: tb/hybrid_rotator_tb_top.sv
module hybrid_rotator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_x = '0;
  logic signed [11:0] in_y = '0;
  logic [12:0] in_phase = '0;
  logic out_valid;
  logic signed [12:0] out_x, out_y;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit ev [0:7];
  int ex_x [0:7];
  int ex_y [0:7];
  string etag [0:7];
  int prev_x = 0;
  int prev_y = 0;

  always #2 clk = ~clk;

  hybrid_rotator dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_phase(in_phase), .out_valid(out_valid), .out_x(out_x), .out_y(out_y));

  function automatic int ref_rot(input int x, input int y, input int code, input bit want_y);
    real th, r;
    th = real'(code) * 3.14159265358979 / 4.0 / 8192.0;
    if (want_y) r = real'(x) * $sin(th) + real'(y) * $cos(th);
    else        r = real'(x) * $cos(th) - real'(y) * $sin(th);
    return $rtoi($floor(r + 0.5));
  endfunction

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  task automatic sample_out();
    int s;
    s = (cyc - 4) & 7;
    checks++;
    if (out_valid !== ev[s]) begin
      errors++;
      $display("FAIL R1: out_valid=%0b expected=%0b at drive %0d", out_valid, ev[s], cyc);
    end
    checks++;
    if (ev[s]) begin
      if (iabs(int'(out_x) - ex_x[s]) > 2 || iabs(int'(out_y) - ex_y[s]) > 2) begin
        errors++;
        $display("FAIL %s: out=(%0d,%0d) expected=(%0d,%0d)", etag[s],
                 int'(out_x), int'(out_y), ex_x[s], ex_y[s]);
      end
    end else begin
      if (int'(out_x) != prev_x || int'(out_y) != prev_y) begin
        errors++;
        $display("FAIL R7: idle out=(%0d,%0d) expected=(%0d,%0d)",
                 int'(out_x), int'(out_y), prev_x, prev_y);
      end
    end
    prev_x = int'(out_x);
    prev_y = int'(out_y);
  endtask

  task automatic drive_cycle(input bit v, input int x, input int y, input int code, input string tag);
    int s;
    @(negedge clk);
    sample_out();
    s = cyc & 7;
    in_valid = v;
    in_x     = 12'(x);
    in_y     = 12'(y);
    in_phase = 13'(code);
    ev[s]    = v;
    ex_x[s]  = ref_rot(x, y, code, 1'b0);
    ex_y[s]  = ref_rot(x, y, code, 1'b1);
    etag[s]  = tag;
    cyc++;
  endtask

  function automatic int rnd12();
    return int'($urandom % 4096) - 2048;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd31337));
    for (int i = 0; i < 8; i++) begin
      ev[i] = 1'b0; ex_x[i] = 0; ex_y[i] = 0; etag[i] = "none";
    end
    repeat (5) @(negedge clk);
    // R6: reset state
    checks++;
    if (out_valid !== 1'b0 || out_x !== 13'sd0 || out_y !== 13'sd0) begin
      errors++;
      $display("FAIL R6: out=(%0b,%0d,%0d) expected=(0,0,0)", out_valid, out_x, out_y);
    end
    rst = 1'b0;

    // R2: zero angle
    drive_cycle(1, 1000, 0, 0, "R2");
    drive_cycle(1, 0, -1500, 0, "R2");
    drive_cycle(1, 2047, -2048, 0, "R2");
    drive_cycle(1, -777, 333, 0, "R2");
    // R8: full-scale corners
    drive_cycle(1, -2048, -2048, 8191, "R8");
    drive_cycle(1, 2047, 2047, 8191, "R8");
    drive_cycle(1, -2048, 2047, 8191, "R8");
    drive_cycle(1, 2047, -2048, 8191, "R8");
    drive_cycle(1, -2048, -2048, 4096, "R8");
    // R4: sweep of codes across the whole range, including all-ones low bits
    for (int c = 0; c < 8192; c += 61) drive_cycle(1, 1800, -900, c, "R4");
    for (int h = 0; h < 8192; h += 1024) drive_cycle(1, -1500, -1700, h + 63, "R4");
    // R5: every low-subword value at a fixed coarse part
    for (int lo = 0; lo < 64; lo++) drive_cycle(1, -1234, 1987, 6720 + lo, "R5");
    // R9: back-to-back random stream
    for (int k = 0; k < 500; k++)
      drive_cycle(1, rnd12(), rnd12(), int'($urandom % 8192), "R9");
    // R3 and R7: random stream with idle gaps carrying junk data
    for (int k = 0; k < 1500; k++)
      drive_cycle(($urandom % 4) != 0, rnd12(), rnd12(), int'($urandom % 8192), "R3");
    for (int k = 0; k < 6; k++) drive_cycle(0, rnd12(), rnd12(), 0, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule